// File: doc/BRIEF.md
# External Interrupt Request Latch

This block turns an active-low, asynchronous external interrupt pin into a request that a simple CPU core can act on. The pin first passes through a synchroniser. A high-to-low transition of the synchronised level sets a sticky request flag, so a pulse only one clock long is still remembered after the pin has gone high again. A configuration input picks the sensitivity. In edge mode only that flag raises the request. In edge-plus-level mode a pin held low also keeps the request up.

The core strobes an instruction-boundary signal each time it finishes an instruction. The block reports an interrupt take only on such a strobe, and only while the core's interrupt mask bit is clear. When the core begins interrupt entry it pulses acknowledge, which clears the sticky flag. A request that arrives while interrupts are masked stays pending until the first boundary after the mask clears.

Top module: `ext_irq_latch`

## Requirements
- R1: While reset is held and on the cycle after it is released, `irqPending` and `irqTake` are both 0. Reset sets the synchroniser and the previous-sample register to the high (idle) level, so no edge is seen after reset.
- R2: A falling edge on `irqPinN` that lasts for at least one clock reaches the synchronised level after two clock edges. On the next edge it sets the sticky flag. `irqPending` therefore goes to 1 in the cycle after the third rising edge that follows the pin going low.
- R3: A low pulse one clock long is remembered. `irqPending` stays 1 after the pin returns high, until an acknowledge clears it.
- R4: With `levelMode` = 0, a pin held low after an acknowledge does not raise `irqPending` again. Only a new falling edge does.
- R5: With `levelMode` = 1, `irqPending` is 1 in every cycle where the synchronised pin level is low, even after an acknowledge.
- R6: `irqTake` is 1 only in a cycle where `instrDone` = 1, `maskBit` = 0 and `irqPending` = 1.
- R7: While `maskBit` = 1, a latched request is kept across any number of boundaries. It produces `irqTake` at the first boundary after `maskBit` returns to 0.
- R8: `intAck` = 1 clears the sticky flag at the next edge. If a new falling edge is seen in the same cycle, the edge wins and the flag stays set.
- R9: A pin that stays high, or that rises, never raises `irqPending`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqPinN | input | 1 | Asynchronous active-low interrupt pin |
| levelMode | input | 1 | 0 = edge only, 1 = edge plus low level |
| instrDone | input | 1 | Instruction-boundary strobe from the core |
| maskBit | input | 1 | Core interrupt mask, 1 = masked |
| intAck | input | 1 | Core acknowledge at interrupt entry |
| irqPending | output | 1 | Request is currently pending |
| irqTake | output | 1 | Start interrupt sequence this boundary |

## Verification
The hardest case to reach from the ports is an acknowledge in the same cycle as a fresh falling edge. The bench must place the pin's drop exactly three edges before a chosen acknowledge cycle, across the two-stage synchroniser, and in a separate phase hold acknowledge high across the whole drop. A second case is a request held across several masked boundaries and then released. For this the bench toggles the mask around repeated boundary strobes. A long random phase then drives all inputs freely against a cycle-accurate behavioural model, with a queue standing in for the synchroniser.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef struct packed {
    logic setLatch;
    logic clrLatch;
  } irqStrobes_t;
endpackage

// File: rtl/ext_irq_dp.sv
module ext_irq_dp
  import ext_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pinN,
  input  irqStrobes_t strb,
  output logic        syncLevel,
  output logic        prevLevel,
  output logic        edgeLatch
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] syncChain;

  always_ff @(posedge clk) begin
    if (!rstN) syncChain <= '1;
    else       syncChain <= {syncChain[LAST-1:0], pinN};
  end

  assign syncLevel = syncChain[LAST];

  always_ff @(posedge clk) begin
    if (!rstN) prevLevel <= 1'b1;
    else       prevLevel <= syncLevel;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              edgeLatch <= 1'b0;
    else if (strb.setLatch) edgeLatch <= 1'b1;
    else if (strb.clrLatch) edgeLatch <= 1'b0;
  end

  AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rstN)
    strb.setLatch |=> edgeLatch);  // R2
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrLatch && !strb.setLatch) |=> !edgeLatch);  // R8
  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (edgeLatch && !strb.clrLatch) |=> edgeLatch);  // R7
  AST_RISE_NEEDS_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(edgeLatch) |-> ($past(prevLevel) && !$past(syncLevel)));  // R9
endmodule

// File: rtl/ext_irq_ctl.sv
module ext_irq_ctl
  import ext_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        syncLevel,
  input  logic        prevLevel,
  input  logic        edgeLatch,
  input  logic        levelMode,
  input  logic        instrDone,
  input  logic        maskBit,
  input  logic        intAck,
  output irqStrobes_t strb,
  output logic        irqPending,
  output logic        irqTake
);
  logic fallSeen;
  logic levelReq;

  always_comb begin
    fallSeen      = prevLevel & ~syncLevel;
    levelReq      = levelMode & ~syncLevel;
    strb.setLatch = fallSeen;
    strb.clrLatch = intAck;
    irqPending    = edgeLatch | levelReq;
    irqTake       = irqPending & instrDone & ~maskBit;
  end

  AST_EDGE_MODE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (!levelMode && !edgeLatch) |-> !irqPending);  // R4
  AST_LEVEL_LOW_PENDS: assert property (@(posedge clk) disable iff (!rstN)
    (levelMode && !syncLevel) |-> irqPending);  // R5
endmodule

// File: rtl/ext_irq_latch.sv
module ext_irq_latch
  import ext_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic irqPinN,
  input  logic levelMode,
  input  logic instrDone,
  input  logic maskBit,
  input  logic intAck,
  output logic irqPending,
  output logic irqTake
);
  irqStrobes_t strb;
  logic syncLevel;
  logic prevLevel;
  logic edgeLatch;

  ext_irq_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .pinN(irqPinN), .strb(strb),
    .syncLevel(syncLevel), .prevLevel(prevLevel), .edgeLatch(edgeLatch)
  );

  ext_irq_ctl u_ctl (
    .clk(clk), .rstN(rstN), .syncLevel(syncLevel), .prevLevel(prevLevel),
    .edgeLatch(edgeLatch), .levelMode(levelMode), .instrDone(instrDone),
    .maskBit(maskBit), .intAck(intAck), .strb(strb),
    .irqPending(irqPending), .irqTake(irqTake)
  );

  AST_TAKE_NEEDS_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    irqTake |-> (instrDone && !maskBit && irqPending));  // R6
endmodule

// File: tb/ext_irq_latch_bench.sv
`timescale 1ns/1ps
module ext_irq_latch_bench;
  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic irqPinN = 1'b1, levelMode = 1'b0, instrDone = 1'b0, maskBit = 1'b0, intAck = 1'b0;
  logic irqPending, irqTake;

  always #4 clk = ~clk;

  ext_irq_latch #(.SYNC_STAGES(SYNC)) u_ext_irq_latch (
    .clk(clk), .rstN(rstN), .irqPinN(irqPinN), .levelMode(levelMode),
    .instrDone(instrDone), .maskBit(maskBit), .intAck(intAck),
    .irqPending(irqPending), .irqTake(irqTake)
  );

  int nChecks = 0;
  int nFails = 0;
  string curReq = "R1";

  bit syncQ[$];
  bit prevM;
  bit latchM;

  function automatic void modelReset();
    syncQ.delete();
    for (int i = 0; i < SYNC; i++) syncQ.push_back(1'b1);
    prevM = 1'b1;
    latchM = 1'b0;
  endfunction

  function automatic void modelEdge();
    bit lvl = syncQ[SYNC-1];
    bit fall = prevM && !lvl;
    if (fall) latchM = 1'b1;
    else if (intAck) latchM = 1'b0;
    prevM = lvl;
    syncQ.push_front(irqPinN);
    void'(syncQ.pop_back());
  endfunction

  task automatic compareNow();
    bit expPend = latchM || (levelMode && !syncQ[SYNC-1]);
    bit expTake = expPend && instrDone && !maskBit;
    nChecks++;
    if (irqPending !== expPend || irqTake !== expTake) begin
      nFails++;
      $display("FAIL %s: pending=%b take=%b expected pending=%b take=%b at %0t",
               curReq, irqPending, irqTake, expPend, expTake, $time);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      if (rstN) modelEdge(); else modelReset();
      @(negedge clk);
      compareNow();
    end
  endtask

  task automatic drive(input bit pin, input bit lvl, input bit done, input bit msk, input bit ack);
    irqPinN = pin; levelMode = lvl; instrDone = done; maskBit = msk; intAck = ack;
  endtask

  initial begin
    #1_000_000;
    nFails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    modelReset();
    curReq = "R1";
    drive(1, 1, 1, 0, 0);
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    // R9: idle high pin, both modes
    curReq = "R9";
    drive(1, 0, 1, 0, 0); cyc(4);
    drive(1, 1, 1, 0, 0); cyc(4);
    // R2: falling edge in edge mode, no boundary yet
    curReq = "R2";
    drive(0, 0, 0, 0, 0); cyc(6);
    // R6: boundary with mask clear gives take
    curReq = "R6";
    drive(0, 0, 1, 0, 0); cyc(1);
    drive(0, 0, 0, 0, 1); cyc(1);
    // R4: held low after ack, edge mode
    curReq = "R4";
    drive(0, 0, 1, 0, 0); cyc(6);
    // R9: rising pin raises nothing
    curReq = "R9";
    drive(1, 0, 1, 0, 0); cyc(5);
    // R3: one-cycle pulse remembered
    curReq = "R3";
    drive(0, 0, 0, 0, 0); cyc(1);
    drive(1, 0, 0, 0, 0); cyc(6);
    // R7: masked boundaries keep request, then release
    curReq = "R7";
    for (int j = 0; j < 3; j++) begin
      drive(1, 0, 1, 1, 0); cyc(1);
      drive(1, 0, 0, 1, 0); cyc(1);
    end
    drive(1, 0, 0, 0, 0); cyc(2);
    drive(1, 0, 1, 0, 0); cyc(1);
    drive(1, 0, 0, 0, 1); cyc(1);
    drive(1, 0, 0, 0, 0); cyc(2);
    // R5: level mode held low survives ack
    curReq = "R5";
    drive(0, 1, 1, 0, 0); cyc(4);
    drive(0, 1, 1, 0, 1); cyc(3);
    drive(0, 1, 1, 0, 0); cyc(3);
    drive(1, 1, 0, 0, 1); cyc(4);
    // R8: ack in the same cycle as a new edge, edge wins then ack clears
    curReq = "R8";
    drive(1, 0, 0, 0, 0); cyc(4);
    drive(0, 0, 0, 0, 0); cyc(2);
    drive(0, 0, 0, 0, 1); cyc(1);
    drive(0, 0, 0, 0, 0); cyc(2);
    drive(0, 0, 0, 0, 1); cyc(1);
    drive(0, 0, 0, 0, 0); cyc(2);
    drive(1, 0, 0, 0, 1); cyc(3);
    drive(0, 0, 0, 0, 1); cyc(5);
    drive(0, 0, 0, 0, 0); cyc(2);
    // R2: random traffic against the model
    curReq = "R2";
    for (int r = 0; r < 2000; r++) begin
      drive(($urandom_range(0, 3) != 0), (r >= 1000), $urandom_range(0, 1),
            ($urandom_range(0, 2) == 0), ($urandom_range(0, 4) == 0));
      cyc(1);
    end
    // R1: reset mid-run clears state
    curReq = "R1";
    drive(0, 0, 1, 0, 0); cyc(5);
    rstN = 1'b0; cyc(2);
    drive(1, 0, 1, 0, 0);
    rstN = 1'b1; cyc(3);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule